// File: doc/BRIEF.md
# Battery Charge Accounting Engine

This block keeps the capacity ledger of a battery monitor. Pulses arrive already scaled and compensated: one kind for each unit of charge put in, one for each unit taken out by a load, and one for each unit lost to estimated self-discharge. From these pulses the block keeps three registers. The available capacity is the charge thought to be in the cell now. The discharge tally counts what has been drawn since the cell was last full. The learned full reference is the capacity of a full cell as last measured.

The learned reference starts at a programmed value. It is replaced by the discharge tally only when a discharge ran from full down to the first end-of-discharge warning without being disturbed. A single update may not lower the reference by more than a quarter. Three status flags go with the ledger: one marks a discharge that still qualifies for learning, one marks that the ledger was reset, and one shows that a charge has proved valid. An outside charge controller can declare the cell full.

Top module: `charge_ledger`

## Requirements
- R1: The full reference in capacity units is the learned value shifted left by FULL_SHIFT. A charge pulse raises the available capacity by one but never above that reference. A discharge or self-discharge pulse lowers it by one but never below zero. A charge pulse in the same cycle as either decrement pulse leaves the capacity unchanged.
- R2: The discharge tally rises by one in each cycle with a discharge pulse, whether or not a charge pulse cancels it. In a cycle with only a self-discharge pulse, it rises by one only while the available capacity is nonzero.
- R3: The discharge tally holds at 16'hFFFF instead of wrapping. In any cycle that starts with the available capacity equal to the full reference, the tally restarts from zero before that cycle's increment is added.
- R4: Charge pulses count as a run while a discharge pulse does not break them and while no gap between them reaches GAP_LIMIT idle cycles. The third pulse of a run is the valid-charge event, and it sets the charge-valid flag. A discharge pulse, or GAP_LIMIT idle cycles after the last charge pulse, clears the flag and restarts the run.
- R5: A discharge pulse arriving while the available capacity equals the full reference sets the qualified-discharge flag.
- R6: Any of the following clears the qualified-discharge flag: a valid-charge event; a rising edge of the end-of-discharge warning while the cold input is high; self-discharge decrements counted since the flag was set, n, reaching n*50 > 3*reference (more than 6%), in which case the flag clears one cycle after the decrement that crosses the threshold.
- R7: The first valid-charge event after a rising edge of the end-of-discharge warning is a learning point. If the qualified-discharge flag is set there, the learned value becomes the larger of (tally >> FULL_SHIFT) and (old learned value − floor(old/4)).
- R8: At a learning point, the available capacity is cleared to zero whether or not learning takes place.
- R9: A charge-complete input sampled high sets the available capacity to the full reference and sets the qualified-discharge flag. It overrides every other update except reset and blocks learning in that cycle.
- R10: A synchronous active-low reset loads the learned value from the programmed full count. It clears the capacity, the tally, the qualified-discharge and charge-valid flags, and sets the replaced flag.
- R11: The replaced flag clears when a charge increment during a valid charge brings the capacity up to the full reference, or at a learning point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| chg_pulse_i | input | 1 | One compensated charge unit |
| dsg_pulse_i | input | 1 | One compensated load discharge unit |
| sdis_pulse_i | input | 1 | One self-discharge unit |
| chg_done_i | input | 1 | Charge controller reports the cell full |
| edv_warn_i | input | 1 | Latched first end-of-discharge warning |
| temp_cold_i | input | 1 | Cell temperature below 0 °C |
| prog_full_i | input | FULL_W | Programmed full count, loaded at reset |
| avail_cap_o | output | 16 | Available capacity |
| dsg_count_o | output | 16 | Discharge tally |
| learned_full_o | output | FULL_W | Learned full reference, unshifted |
| qual_dsg_o | output | 1 | Qualified-discharge flag |
| replaced_o | output | 1 | Ledger was reset |
| chg_valid_o | output | 1 | Charge has proved valid |

## Verification
The bench builds the block with FULL_SHIFT = 2 and GAP_LIMIT = 8 and keeps FULL_W at 8. With these values the full reference is a few dozen units, so the bench can charge the cell to its ceiling, drain it to zero and reach the 6% self-discharge boundary in a few hundred cycles. A short charge gap can be timed out, and every one of the 256 programmed counts can be loaded through reset. The 16-bit tally is still driven into saturation, and two learning points are set up so that one uses the measured tally and the other is held by the 25% floor.

// File: rtl/ledger_pkg.sv
// Shared types and helpers for the charge ledger.
// Assumes all capacity quantities fit a 16-bit unsigned word.
package ledger_pkg;
    localparam int unsigned CAP_W = 16;
    typedef logic [CAP_W-1:0] cap_t;

    // Increment that sticks at all ones instead of wrapping.
    function automatic cap_t cap_sat_inc(input cap_t v);
        return (v == '1) ? v : v + cap_t'(1);
    endfunction
endpackage

// File: rtl/charge_qualifier.sv
// Decides when charge activity has become a valid charge.
// Counts consecutive charge pulses. A discharge pulse or a long gap
// without charge pulses ends the run. Emits a one-cycle event on the
// pulse that completes the run and holds a status flag afterwards.
// Assumes VALID_RUN >= 1 and GAP_LIMIT >= 2.
module charge_qualifier #(
    parameter int unsigned VALID_RUN = 3,
    parameter int unsigned GAP_LIMIT = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic chg_i,
    input  logic dsg_i,
    output logic valid_evt_o,
    output logic chg_valid_o
);
    localparam int unsigned RUN_W = $clog2(VALID_RUN + 1);
    localparam int unsigned GAP_W = $clog2(GAP_LIMIT);
    localparam logic [RUN_W-1:0] RUN_DONE = RUN_W'(VALID_RUN);
    localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(VALID_RUN - 1);
    localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'(GAP_LIMIT - 1);

    logic [RUN_W-1:0] run_q;
    logic [GAP_W-1:0] gap_q;
    logic             flag_q;
    logic             timeout;

    // Activity is deemed stopped once a run sees GAP_LIMIT idle cycles.
    always_comb timeout = (run_q != '0) && !chg_i && (gap_q == GAP_LAST);

    // The pulse that completes the run, unless a discharge breaks it.
    always_comb valid_evt_o = chg_i && !dsg_i && (run_q == RUN_LAST);

    // Run length: discharge or timeout restart it, charge extends it.
    always_ff @(posedge clk) begin
        if (!rst_n)                  run_q <= '0;
        else if (dsg_i || timeout)   run_q <= '0;
        else if (chg_i && run_q != RUN_DONE) run_q <= run_q + RUN_W'(1);
    end

    // Idle-cycle counter since the last charge pulse of an open run.
    always_ff @(posedge clk) begin
        if (!rst_n)                                    gap_q <= '0;
        else if (chg_i || run_q == '0 || timeout)      gap_q <= '0;
        else                                           gap_q <= gap_q + GAP_W'(1);
    end

    // Charge-valid status flag.
    always_ff @(posedge clk) begin
        if (!rst_n)                flag_q <= 1'b0;
        else if (dsg_i || timeout) flag_q <= 1'b0;
        else if (valid_evt_o)      flag_q <= 1'b1;
    end

    assign chg_valid_o = flag_q;
endmodule

// File: rtl/capacity_counter.sv
// Available-capacity register. Moves by one per cycle between zero and
// the full reference. Forced-full and clear requests override counting.
// Assumes the full reference fits the capacity word.
module capacity_counter
    import ledger_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic inc_req_i,
    input  logic dec_req_i,
    input  logic force_full_i,
    input  logic clear_i,
    input  cap_t full_ref_i,
    output cap_t avail_o,
    output logic inc_taken_o,
    output logic at_full_o
);
    cap_t avail_q;
    logic dec_taken;

    // An increment lands only when uncontested and below the ceiling.
    always_comb inc_taken_o = inc_req_i && !dec_req_i && (avail_q < full_ref_i);

    // A decrement lands only when uncontested and above zero.
    always_comb dec_taken = dec_req_i && !inc_req_i && (avail_q != '0);

    // Ceiling comparison shared with the tally and flag logic.
    always_comb at_full_o = (avail_q == full_ref_i);

    // Capacity update with override priority.
    always_ff @(posedge clk) begin
        if (!rst_n)            avail_q <= '0;
        else if (force_full_i) avail_q <= full_ref_i;
        else if (clear_i)      avail_q <= '0;
        else if (inc_taken_o)  avail_q <= avail_q + cap_t'(1);
        else if (dec_taken)    avail_q <= avail_q - cap_t'(1);
    end

    assign avail_o = avail_q;
endmodule

// File: rtl/discharge_tally.sv
// Counts charge drawn since the cell was last full.
// Restarts from zero in any cycle that begins at the full reference.
// Saturates at all ones.
module discharge_tally
    import ledger_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic dsg_i,
    input  logic sdis_i,
    input  logic avail_nonzero_i,
    input  logic at_full_i,
    output cap_t tally_o
);
    cap_t tally_q;
    cap_t base;
    logic bump;

    // Base value: zero while the cell sits at full.
    always_comb base = at_full_i ? '0 : tally_q;

    // Load pulses always count; self-discharge only while charge remains.
    always_comb bump = dsg_i || (sdis_i && avail_nonzero_i);

    // Tally register.
    always_ff @(posedge clk) begin
        if (!rst_n) tally_q <= '0;
        else        tally_q <= bump ? cap_sat_inc(base) : base;
    end

    assign tally_o = tally_q;
endmodule

// File: rtl/capacity_learner.sv
// Holds the learned full reference and the qualification flags.
// Detects the end-of-discharge rising edge, tracks self-discharge loss
// since the qualified-discharge flag was set, and moves the tally into
// the reference at a learning point, limited to a 25% drop.
// Assumes FULL_W + FULL_SHIFT <= 16.
module capacity_learner
    import ledger_pkg::*;
#(
    parameter int unsigned FULL_W     = 8,
    parameter int unsigned FULL_SHIFT = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FULL_W-1:0] prog_full_i,
    input  logic              dsg_i,
    input  logic              sdis_taken_i,
    input  logic              at_full_i,
    input  cap_t              tally_i,
    input  logic              valid_evt_i,
    input  logic              fill_by_charge_i,
    input  logic              done_i,
    input  logic              edv_i,
    input  logic              cold_i,
    output logic [FULL_W-1:0] learned_o,
    output cap_t              full_ref_o,
    output logic              learn_point_o,
    output logic              qual_o,
    output logic              replaced_o
);
    localparam int unsigned PROD_W  = CAP_W + 7;
    localparam int unsigned SHIFT_W = CAP_W - FULL_SHIFT;
    localparam logic [SHIFT_W-1:0] FULL_MAX = SHIFT_W'({FULL_W{1'b1}});

    logic [FULL_W-1:0]  learned_q;
    logic               qual_q;
    logic               repl_q;
    logic               edv_prev_q;
    logic               edv_arm_q;
    cap_t               sd_loss_q;
    logic               edv_rise;
    logic               post_edv;
    logic               cold_rise;
    logic               sd_over;
    logic [SHIFT_W-1:0] cand_wide;
    logic [FULL_W-1:0]  cand;
    logic [FULL_W-1:0]  floor_v;
    logic [FULL_W-1:0]  next_learned;

    // Scaled reference used by every capacity comparison.
    always_comb full_ref_o = cap_t'(learned_q) << FULL_SHIFT;

    // Warning edge and the armed state that outlives it.
    always_comb begin
        edv_rise  = edv_i && !edv_prev_q;
        post_edv  = edv_arm_q || edv_rise;
        cold_rise = edv_rise && cold_i;
    end

    // Learning point: first valid charge after the warning, not overridden.
    always_comb learn_point_o = valid_evt_i && post_edv && !done_i;

    // Self-discharge loss above 6% of the reference: n*50 > ref*3.
    always_comb sd_over = (PROD_W'(sd_loss_q) * PROD_W'(50)) > (PROD_W'(full_ref_o) * PROD_W'(3));

    // Candidate reference from the tally, limited to a 25% drop.
    always_comb begin
        cand_wide    = SHIFT_W'(tally_i >> FULL_SHIFT);
        cand         = (cand_wide > FULL_MAX) ? '1 : FULL_W'(cand_wide);
        floor_v      = learned_q - (learned_q >> 2);
        next_learned = (cand < floor_v) ? floor_v : cand;
    end

    // Learned reference: programmed at reset, replaced at a qualified learning point.
    always_ff @(posedge clk) begin
        if (!rst_n)                      learned_q <= prog_full_i;
        else if (learn_point_o && qual_q) learned_q <= next_learned;
    end

    // Qualified-discharge flag with charge-complete taking priority.
    always_ff @(posedge clk) begin
        if (!rst_n)                                  qual_q <= 1'b0;
        else if (done_i)                             qual_q <= 1'b1;
        else if (valid_evt_i || cold_rise || sd_over) qual_q <= 1'b0;
        else if (dsg_i && at_full_i)                 qual_q <= 1'b1;
    end

    // Self-discharge loss counted only while the flag is set.
    always_ff @(posedge clk) begin
        if (!rst_n || !qual_q) sd_loss_q <= '0;
        else if (sdis_taken_i) sd_loss_q <= cap_sat_inc(sd_loss_q);
    end

    // Replaced flag: set by reset, cleared by a proven refill or learning point.
    always_ff @(posedge clk) begin
        if (!rst_n)                                               repl_q <= 1'b1;
        else if ((valid_evt_i && post_edv) || fill_by_charge_i)   repl_q <= 1'b0;
    end

    // Warning history for edge detection and arming.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            edv_prev_q <= 1'b0;
            edv_arm_q  <= 1'b0;
        end else begin
            edv_prev_q <= edv_i;
            if (valid_evt_i)   edv_arm_q <= 1'b0;
            else if (edv_rise) edv_arm_q <= 1'b1;
        end
    end

    assign learned_o  = learned_q;
    assign qual_o     = qual_q;
    assign replaced_o = repl_q;
endmodule

// File: rtl/charge_ledger.sv
// Top of the battery charge accounting engine.
// Connects the charge qualifier, capacity counter, discharge tally and
// learner. Assumes input pulses are single-cycle, already compensated
// and synchronous to clk.
module charge_ledger
    import ledger_pkg::*;
#(
    parameter int unsigned FULL_W     = 8,
    parameter int unsigned FULL_SHIFT = 8,
    parameter int unsigned VALID_RUN  = 3,
    parameter int unsigned GAP_LIMIT  = 4096
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chg_pulse_i,
    input  logic              dsg_pulse_i,
    input  logic              sdis_pulse_i,
    input  logic              chg_done_i,
    input  logic              edv_warn_i,
    input  logic              temp_cold_i,
    input  logic [FULL_W-1:0] prog_full_i,
    output logic [15:0]       avail_cap_o,
    output logic [15:0]       dsg_count_o,
    output logic [FULL_W-1:0] learned_full_o,
    output logic              qual_dsg_o,
    output logic              replaced_o,
    output logic              chg_valid_o
);
    cap_t full_ref;
    cap_t avail;
    cap_t tally;
    logic valid_evt;
    logic learn_point;
    logic inc_taken;
    logic at_full;
    logic dec_req;
    logic sdis_taken;
    logic fill_by_charge;

    // Decrement request and the self-discharge share of it.
    always_comb begin
        dec_req    = dsg_pulse_i || sdis_pulse_i;
        sdis_taken = sdis_pulse_i && !chg_pulse_i && (avail != '0);
    end

    // A proven charge increment that lands exactly on the reference.
    always_comb fill_by_charge = (chg_valid_o || valid_evt) && inc_taken
                                 && ((avail + cap_t'(1)) == full_ref);

    charge_qualifier #(
        .VALID_RUN (VALID_RUN),
        .GAP_LIMIT (GAP_LIMIT)
    ) u_qual (
        .clk         (clk),
        .rst_n       (rst_n),
        .chg_i       (chg_pulse_i),
        .dsg_i       (dsg_pulse_i),
        .valid_evt_o (valid_evt),
        .chg_valid_o (chg_valid_o)
    );

    capacity_counter u_cap (
        .clk          (clk),
        .rst_n        (rst_n),
        .inc_req_i    (chg_pulse_i),
        .dec_req_i    (dec_req),
        .force_full_i (chg_done_i),
        .clear_i      (learn_point),
        .full_ref_i   (full_ref),
        .avail_o      (avail),
        .inc_taken_o  (inc_taken),
        .at_full_o    (at_full)
    );

    discharge_tally u_tally (
        .clk             (clk),
        .rst_n           (rst_n),
        .dsg_i           (dsg_pulse_i),
        .sdis_i          (sdis_pulse_i),
        .avail_nonzero_i (avail != '0),
        .at_full_i       (at_full),
        .tally_o         (tally)
    );

    capacity_learner #(
        .FULL_W     (FULL_W),
        .FULL_SHIFT (FULL_SHIFT)
    ) u_learn (
        .clk              (clk),
        .rst_n            (rst_n),
        .prog_full_i      (prog_full_i),
        .dsg_i            (dsg_pulse_i),
        .sdis_taken_i     (sdis_taken),
        .at_full_i        (at_full),
        .tally_i          (tally),
        .valid_evt_i      (valid_evt),
        .fill_by_charge_i (fill_by_charge),
        .done_i           (chg_done_i),
        .edv_i            (edv_warn_i),
        .cold_i           (temp_cold_i),
        .learned_o        (learned_full_o),
        .full_ref_o       (full_ref),
        .learn_point_o    (learn_point),
        .qual_o           (qual_dsg_o),
        .replaced_o       (replaced_o)
    );

    assign avail_cap_o = avail;
    assign dsg_count_o = tally;
endmodule

// File: rtl/charge_ledger_checks.sv
// Port-level temporal checks for charge_ledger, attached by bind.
module charge_ledger_checks #(
    parameter int unsigned FULL_W     = 8,
    parameter int unsigned FULL_SHIFT = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              chg_pulse_i,
    input logic              dsg_pulse_i,
    input logic              chg_done_i,
    input logic [15:0]       avail_cap_o,
    input logic [15:0]       dsg_count_o,
    input logic [FULL_W-1:0] learned_full_o,
    input logic              qual_dsg_o,
    input logic              chg_valid_o
);
    logic [15:0] full_ref;
    always_comb full_ref = 16'(learned_full_o) << FULL_SHIFT;

    assert_cap_ceiling_R1: assert property (@(posedge clk) disable iff (!rst_n)
        avail_cap_o <= full_ref);

    assert_no_underflow_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (avail_cap_o == 16'd0 && !chg_pulse_i && !chg_done_i) |=> avail_cap_o == 16'd0);

    assert_tally_sticks_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (dsg_count_o == 16'hFFFF && avail_cap_o != full_ref) |=> dsg_count_o == 16'hFFFF);

    assert_valid_from_charge_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(chg_valid_o) |-> ($past(chg_pulse_i) && !$past(dsg_pulse_i)));

    assert_dsg_drops_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
        dsg_pulse_i |=> !chg_valid_o);

    assert_learn_floor_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$stable(learned_full_o)) |->
        ({1'b0, learned_full_o} >= ({1'b0, $past(learned_full_o)} - {3'b0, $past(learned_full_o) >> 2})));

    assert_done_fills_R9: assert property (@(posedge clk) disable iff (!rst_n)
        chg_done_i |=> (avail_cap_o == $past(full_ref) && qual_dsg_o));
endmodule

bind charge_ledger charge_ledger_checks #(
    .FULL_W     (FULL_W),
    .FULL_SHIFT (FULL_SHIFT)
) u_checks (
    .clk            (clk),
    .rst_n          (rst_n),
    .chg_pulse_i    (chg_pulse_i),
    .dsg_pulse_i    (dsg_pulse_i),
    .chg_done_i     (chg_done_i),
    .avail_cap_o    (avail_cap_o),
    .dsg_count_o    (dsg_count_o),
    .learned_full_o (learned_full_o),
    .qual_dsg_o     (qual_dsg_o),
    .chg_valid_o    (chg_valid_o)
);

// File: tb/charge_ledger_tb.sv
module charge_ledger_tb;
    localparam int unsigned FW = 8;
    localparam int unsigned SH = 2;
    localparam int unsigned GAP = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          chg = 1'b0, dsg = 1'b0, sd = 1'b0, done = 1'b0;
    logic          edv = 1'b0, cold = 1'b0;
    logic [FW-1:0] prog = '0;
    logic [15:0]   avail, tally;
    logic [FW-1:0] learned;
    logic          qual, repl, cvalid;

    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    charge_ledger #(.FULL_W(FW), .FULL_SHIFT(SH), .VALID_RUN(3), .GAP_LIMIT(GAP)) u_dut (
        .clk(clk), .rst_n(rst_n), .chg_pulse_i(chg), .dsg_pulse_i(dsg),
        .sdis_pulse_i(sd), .chg_done_i(done), .edv_warn_i(edv), .temp_cold_i(cold),
        .prog_full_i(prog), .avail_cap_o(avail), .dsg_count_o(tally),
        .learned_full_o(learned), .qual_dsg_o(qual), .replaced_o(repl),
        .chg_valid_o(cvalid)
    );

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // One pulse cycle followed by one idle cycle; outputs settled on return.
    task automatic step(input logic c, input logic d, input logic s);
        @(negedge clk); chg = c; dsg = d; sd = s;
        @(negedge clk); chg = 1'b0; dsg = 1'b0; sd = 1'b0;
    endtask

    task automatic steps(input int n, input logic c, input logic d, input logic s);
        for (int i = 0; i < n; i++) step(c, d, s);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset(input logic [FW-1:0] pf);
        @(negedge clk); rst_n = 1'b0; prog = pf;
        idle(3);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            fails++; tests++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        // R10: reset state for every programmed count
        for (int pf = 0; pf < 256; pf++) begin
            do_reset(FW'(pf));
            chk("R10", "reset state",
                {learned, avail, tally, qual, repl, cvalid},
                {FW'(pf), 16'd0, 16'd0, 1'b0, 1'b1, 1'b0});
        end

        // Reference 10 -> 40 units
        do_reset(8'd10);
        steps(2, 1, 0, 0);
        chk("R4", "valid after two pulses", cvalid, 0);
        chk("R1", "capacity after two charges", avail, 2);
        step(1, 0, 0);
        chk("R4", "valid after third pulse", cvalid, 1);
        steps(47, 1, 0, 0);
        chk("R1", "capacity capped at reference", avail, 40);
        chk("R11", "replaced cleared at full", repl, 0);
        idle(1);
        chk("R3", "tally zero at full", tally, 0);
        idle(10);
        chk("R4", "valid cleared by gap", cvalid, 0);

        step(0, 1, 0);
        chk("R5", "qualified set leaving full", qual, 1);
        chk("R1", "capacity after discharge", avail, 39);
        chk("R2", "tally after discharge", tally, 1);
        step(1, 1, 0);
        chk("R1", "cancel keeps capacity", avail, 39);
        chk("R2", "cancelled discharge still tallied", tally, 2);
        steps(39, 0, 1, 0);
        steps(5, 0, 1, 0);
        chk("R1", "capacity floor at zero", avail, 0);
        chk("R2", "tally past empty", tally, 46);
        step(0, 0, 1);
        chk("R2", "self-discharge ignored at empty", tally, 46);
        chk("R1", "capacity stays zero", avail, 0);

        // First learning point: 46>>2 = 11 beats floor 8
        @(negedge clk); edv = 1'b1;
        steps(2, 1, 0, 0);
        chk("R1", "charges before valid", avail, 2);
        step(1, 0, 0);
        chk("R8", "capacity cleared at learning point", avail, 0);
        chk("R7", "learned from tally", learned, 11);
        chk("R6", "qualified cleared by valid charge", qual, 0);
        edv = 1'b0;
        steps(44, 1, 0, 0);
        chk("R1", "refill to new reference", avail, 44);
        idle(1);
        chk("R3", "tally cleared at new full", tally, 0);
        step(0, 1, 0);
        chk("R4", "discharge clears valid", cvalid, 0);
        chk("R5", "qualified set again", qual, 1);
        steps(19, 0, 1, 0);
        chk("R2", "tally before second learn", tally, 20);

        // Second learning point: 20>>2 = 5, floor 11-2 = 9
        @(negedge clk); edv = 1'b1;
        idle(2);
        steps(3, 1, 0, 0);
        chk("R7", "drop limited to quarter", learned, 9);
        chk("R8", "capacity cleared again", avail, 0);
        edv = 1'b0;

        // Cold warning drops qualification; no learning
        steps(36, 1, 0, 0);
        chk("R1", "full at 36", avail, 36);
        step(0, 1, 0);
        chk("R5", "qualified before cold warning", qual, 1);
        @(negedge clk); cold = 1'b1; edv = 1'b1;
        idle(2);
        chk("R6", "cold warning clears qualified", qual, 0);
        steps(3, 1, 0, 0);
        chk("R8", "cleared without learning", avail, 0);
        chk("R7", "no learning when unqualified", learned, 9);
        cold = 1'b0; edv = 1'b0;
        idle(2);

        // Self-discharge over 6% of 36: third unit (150 > 108)
        steps(36, 1, 0, 0);
        step(0, 1, 0);
        steps(2, 0, 0, 1);
        idle(1);
        chk("R6", "qualified held at two units", qual, 1);
        step(0, 0, 1);
        idle(1);
        chk("R6", "qualified cleared past 6%", qual, 0);
        chk("R1", "capacity after self-discharge", avail, 32);
        chk("R2", "self-discharge tallied", tally, 4);

        // Charge complete
        @(negedge clk); done = 1'b1;
        @(negedge clk); done = 1'b0;
        chk("R9", "done fills capacity", avail, 36);
        chk("R9", "done sets qualified", qual, 1);
        idle(1);
        chk("R3", "tally cleared after done", tally, 0);

        // Tally saturation
        @(negedge clk); dsg = 1'b1;
        repeat (65540) @(negedge clk);
        dsg = 1'b0;
        chk("R3", "tally saturates", tally, 16'hFFFF);
        chk("R1", "capacity empty after long drain", avail, 0);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule